// File: doc/BRIEF.md
# Channel Enable Timing Sequencer

This block turns one channel-enable input into a set of delayed control outputs. It produces an analog-on level, an external-on level for an antenna switch or low-noise amplifier, and a digital-datapath-on level. Each edge of the output follows an edge of the enable after a programmed number of system clock cycles. Power-up and power-down work for the active power-saving mode is modelled as single-cycle request pulses. The pulses are placed so that the power-up work finishes just as the analog section turns on, and the power-down work starts right after it turns off.

Two checks run alongside the sequencing. The programmed delays are checked against ordering rules, and these rules differ between a transmit channel and a receive channel. The requested power-saving mode is lowered when the rise-to-analog-on delay leaves too little lead time for that mode's extra power-up work. A third flag reports a new rising edge of the enable that arrives before the previous frame's power-down window has elapsed.

All delays are `CW` bits wide. The default of 24 bits holds roughly 16.8 million cycles, which covers about 91 ms at 184.32 MHz. The reachable time scales with the clock frequency.

Top module: `chan_en_seq`

## Requirements
- R1: `ana_on` becomes 1 exactly `rise_ana_dly` clock edges after the first edge that samples `ch_en` high. A delay of 0 makes it rise at that first edge.
- R2: `ana_on` becomes 0 exactly `fall_off_dly` clock edges after the first edge that samples `ch_en` low.
- R3: When `ext_used` is 1, `ext_on` rises `rise_on_dly` edges after the enable rising edge and falls `fall_off_dly` edges after the falling edge. When `ext_used` is 0, `ext_on` stays 0.
- R4: `dp_on` rises at the first edge that samples `ch_en` high. It falls `hold_dly` edges after the first edge that samples `ch_en` low.
- R5: A new enable edge cancels every output change still pending from the previous edge. Timing restarts from the new edge.
- R6: `cfg_err` is 1 when `ext_used` is 1 and `rise_on_dly < rise_ana_dly`.
- R7: `cfg_err` is also 1 when `is_tx`=1 and `hold_dly > fall_off_dly`, or when `is_tx`=0 and `fall_off_dly > hold_dly`. Otherwise, with no R6 violation, it is 0.
- R8: `psm_eff` is set as follows. It equals `psm_req` (2 = mode 2, 3 = mode 3) when `psm_req` is 2 or more and `rise_ana_dly > pu2_t`. Otherwise it is 1 when `psm_req` is nonzero and `rise_ana_dly > pu1_t`. Otherwise it is 0.
- R9: When `psm_eff` is nonzero at a rising edge, `pu_req` pulses high for exactly one cycle, and this pulse leads the `ana_on` rise by the mode's power-up time (`pu1_t` for mode 1, `pu2_t` for modes 2 and 3). In mode 0, no pulse is issued.
- R10: When `psm_eff` is nonzero, `pd_req` is high for exactly one cycle, namely the cycle in which `ana_on` falls. In mode 0, no pulse is issued.
- R11: Let G = `hold_dly` plus the power-down time of the active mode (`pd1_t`, `pd2_t`, or 0 in mode 0). At each rising edge, `ovl_err` becomes 1 if fewer than G edges separate that edge from the previous falling edge, and becomes 0 otherwise.
- R12: While `rst_n` is low, `ana_on`, `ext_on`, `dp_on`, `pu_req`, `pd_req` and `ovl_err` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| ch_en | input | 1 | Channel enable |
| is_tx | input | 1 | 1 = transmit channel, 0 = receive channel |
| ext_used | input | 1 | External-on output in use |
| psm_req | input | 2 | Requested power-saving mode |
| rise_ana_dly | input | CW | Enable rise to analog on, in cycles |
| rise_on_dly | input | CW | Enable rise to external on, in cycles |
| fall_off_dly | input | CW | Enable fall to analog and external off, in cycles |
| hold_dly | input | CW | Enable fall to datapath off, in cycles |
| pu1_t | input | CW | Mode-1 extra power-up time |
| pu2_t | input | CW | Mode-2/3 extra power-up time |
| pd1_t | input | CW | Mode-1 extra power-down time |
| pd2_t | input | CW | Mode-2/3 extra power-down time |
| ana_on | output | 1 | Analog section on |
| ext_on | output | 1 | External switch or amplifier on |
| dp_on | output | 1 | Digital datapath on |
| pu_req | output | 1 | Power-up request pulse |
| pd_req | output | 1 | Power-down request pulse |
| cfg_err | output | 1 | Delay ordering violation |
| ovl_err | output | 1 | Frame overlap violation at last rising edge |
| psm_eff | output | 2 | Power-saving mode actually applied |

## Verification
The hardest situations to reach are an enable edge that lands while a delayed change is still counting, and a rising edge placed exactly at the overlap limit or one cycle before it. Random frames never produce these, because each frame holds its level long enough for every delay to expire. Directed sequences therefore toggle the enable after a counted number of clock cycles. One sequence drops the enable before the analog rise is due. Another raises it again before the analog fall is due. Others space a fall and the next rise by G-1 and by G edges, both with and without a power-down time in the gap.

// File: rtl/chan_en_seq.sv
module chan_en_seq #(
  parameter int CW = 24
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          ch_en,
  input  logic          is_tx,
  input  logic          ext_used,
  input  logic [1:0]    psm_req,
  input  logic [CW-1:0] rise_ana_dly,
  input  logic [CW-1:0] rise_on_dly,
  input  logic [CW-1:0] fall_off_dly,
  input  logic [CW-1:0] hold_dly,
  input  logic [CW-1:0] pu1_t,
  input  logic [CW-1:0] pu2_t,
  input  logic [CW-1:0] pd1_t,
  input  logic [CW-1:0] pd2_t,
  output logic          ana_on,
  output logic          ext_on,
  output logic          dp_on,
  output logic          pu_req,
  output logic          pd_req,
  output logic          cfg_err,
  output logic          ovl_err,
  output logic [1:0]    psm_eff
);
  localparam int NCH = 3;
  localparam int GW  = CW + 1;

  logic en_q, ana_d;
  wire rise_e = ch_en & ~en_q;
  wire fall_e = ~ch_en & en_q;

  wire ok1 = rise_ana_dly > pu1_t;
  wire ok2 = rise_ana_dly > pu2_t;
  assign psm_eff = (psm_req >= 2'd2 && ok2) ? psm_req :
                   (psm_req != 2'd0 && ok1) ? 2'd1 : 2'd0;

  assign cfg_err = (ext_used && rise_on_dly < rise_ana_dly) ||
                   (is_tx ? (hold_dly > fall_off_dly) : (fall_off_dly > hold_dly));

  logic [CW-1:0] pu_t, pd_t;
  always_comb begin
    case (psm_eff)
      2'd0:    begin pu_t = '0;    pd_t = '0;    end
      2'd1:    begin pu_t = pu1_t; pd_t = pd1_t; end
      default: begin pu_t = pu2_t; pd_t = pd2_t; end
    endcase
  end

  // per output: delay after rise, delay after fall, level reached after rise
  logic [CW-1:0] rd [NCH];
  logic [CW-1:0] fd [NCH];
  logic [NCH-1:0] rlvl, q;
  always_comb begin
    rd[0] = rise_ana_dly; fd[0] = fall_off_dly; rlvl[0] = 1'b1;
    rd[1] = rise_on_dly;  fd[1] = fall_off_dly; rlvl[1] = ext_used;
    rd[2] = '0;           fd[2] = hold_dly;     rlvl[2] = 1'b1;
  end

  for (genvar g = 0; g < NCH; g++) begin : g_ch
    logic          q_r, busy, tgt;
    logic [CW-1:0] cnt;
    wire  [CW-1:0] ld = rise_e ? rd[g] : fd[g];
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        q_r <= 1'b0; busy <= 1'b0; tgt <= 1'b0; cnt <= '0;
      end else if (rise_e || fall_e) begin
        if (ld == '0) begin
          q_r  <= rise_e & rlvl[g];
          busy <= 1'b0;
        end else begin
          cnt  <= ld;
          tgt  <= rise_e & rlvl[g];
          busy <= 1'b1;
        end
      end else if (busy) begin
        if (cnt == CW'(1)) begin
          q_r  <= tgt;
          busy <= 1'b0;
        end
        cnt <= cnt - CW'(1);
      end
    end
    assign q[g] = q_r;
  end

  assign ana_on = q[0];
  assign ext_on = q[1];
  assign dp_on  = q[2];
  assign pd_req = ana_d & ~ana_on & (psm_eff != 2'd0);

  logic          pbusy;
  logic [CW-1:0] pcnt;
  logic [GW-1:0] gcnt;
  wire  [GW-1:0] gap = {1'b0, hold_dly} + {1'b0, pd_t};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q <= 1'b0; ana_d <= 1'b0;
      pbusy <= 1'b0; pcnt <= '0; pu_req <= 1'b0;
      gcnt <= '0; ovl_err <= 1'b0;
    end else begin
      en_q   <= ch_en;
      ana_d  <= ana_on;
      pu_req <= 1'b0;
      if (rise_e) begin
        pbusy <= psm_eff != 2'd0;
        pcnt  <= rise_ana_dly - pu_t;
      end else if (fall_e) begin
        pbusy <= 1'b0;
      end else if (pbusy) begin
        if (pcnt == CW'(1)) begin
          pu_req <= 1'b1;
          pbusy  <= 1'b0;
        end
        pcnt <= pcnt - CW'(1);
      end
      if (fall_e)
        gcnt <= (gap == '0) ? '0 : gap - GW'(1);
      else if (gcnt != '0)
        gcnt <= gcnt - GW'(1);
      if (rise_e)
        ovl_err <= gcnt != '0;
    end
  end
endmodule

// File: rtl/chan_en_seq_chk.sv
module chan_en_seq_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       ch_en,
  input logic [1:0] psm_req,
  input logic       ana_on,
  input logic       dp_on,
  input logic       pu_req,
  input logic       pd_req,
  input logic [1:0] psm_eff
);
  p_ana_rise_r1: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ana_on) |-> $past(ch_en));
  p_ana_fall_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(ana_on) |-> !$past(ch_en));
  p_dp_rise_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(dp_on) |-> $past(ch_en) && !$past(ch_en, 2));
  p_mode_cap_r8: assert property (@(posedge clk) disable iff (!rst_n)
    psm_eff <= psm_req);
  p_pu_pulse_r9: assert property (@(posedge clk) disable iff (!rst_n)
    pu_req |=> !pu_req);
  p_pd_pulse_r10: assert property (@(posedge clk) disable iff (!rst_n)
    pd_req |=> !pd_req);
endmodule

bind chan_en_seq chan_en_seq_chk u_chk (
  .clk(clk), .rst_n(rst_n), .ch_en(ch_en), .psm_req(psm_req),
  .ana_on(ana_on), .dp_on(dp_on), .pu_req(pu_req), .pd_req(pd_req),
  .psm_eff(psm_eff)
);

// File: tb/chan_en_seq_bench.sv
module chan_en_seq_bench;
  localparam int W = 70;
  logic clk = 0, rst_n = 0, ch_en = 0, is_tx = 0, ext_used = 0;
  logic [1:0] psm_req = 0;
  logic [23:0] rise_ana_dly = 0, rise_on_dly = 0, fall_off_dly = 0, hold_dly = 0;
  logic [23:0] pu1_t = 0, pu2_t = 0, pd1_t = 0, pd2_t = 0;
  logic ana_on, ext_on, dp_on, pu_req, pd_req, cfg_err, ovl_err;
  logic [1:0] psm_eff;
  int errors = 0, checks = 0, cyc = 0;
  bit done = 0;

  always #5 clk = ~clk;

  chan_en_seq u_chan_en_seq (.*);

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000 && !done) begin
      done = 1; errors++; checks++;
      $display("FAIL watchdog actual=%0d expected=%0d", cyc, 150000);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  task automatic check(string tag, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  function automatic int exp_mode(int rq, int ra, int p1, int p2);
    if (rq >= 2 && ra > p2) return rq;
    if (rq != 0 && ra > p1) return 1;
    return 0;
  endfunction

  function automatic int exp_cfg(bit tx, bit eu, int ra, int ro, int fo, int ho);
    return int'((eu && ro < ra) || (tx ? ho > fo : fo > ho));
  endfunction

  task automatic setp(int ra, int ro, int fo, int ho, int p1, int p2, int d1, int d2,
                      bit tx, bit eu, int rq);
    rise_ana_dly = 24'(ra); rise_on_dly = 24'(ro); fall_off_dly = 24'(fo); hold_dly = 24'(ho);
    pu1_t = 24'(p1); pu2_t = 24'(p2); pd1_t = 24'(d1); pd2_t = 24'(d2);
    is_tx = tx; ext_used = eu; psm_req = 2'(rq);
  endtask

  task automatic run_frame(int ra, int ro, int fo, int ho, int p1, int p2, int d1, int d2,
                           bit tx, bit eu, int rq);
    int em, put, t_a, t_e, t_d, t_p, n_p, n_e, n_d;
    @(negedge clk);
    setp(ra, ro, fo, ho, p1, p2, d1, d2, tx, eu, rq);
    #1;
    em = exp_mode(rq, ra, p1, p2);
    put = (em == 0) ? 0 : (em == 1) ? p1 : p2;
    check("R8 mode", int'(psm_eff), em);
    check("R6 R7 cfg", int'(cfg_err), exp_cfg(tx, eu, ra, ro, fo, ho));
    ch_en = 1;
    t_a = -1; t_e = -1; t_d = -1; t_p = -1; n_p = 0; n_e = 0;
    for (int i = 1; i <= W; i++) begin
      @(negedge clk);
      if (i == 1) check("R11 no overlap", int'(ovl_err), 0);
      if (ana_on && t_a < 0) t_a = i;
      if (ext_on) begin n_e++; if (t_e < 0) t_e = i; end
      if (dp_on && t_d < 0) t_d = i;
      if (pu_req) begin n_p++; if (t_p < 0) t_p = i; end
    end
    check("R1 ana rise", t_a, ra + 1);
    if (eu) check("R3 ext rise", t_e, ro + 1);
    else    check("R3 ext unused", n_e, 0);
    check("R4 dp rise", t_d, 1);
    check("R9 pu count", n_p, em != 0 ? 1 : 0);
    if (em != 0) check("R9 pu time", t_p, ra - put + 1);
    ch_en = 0;
    t_a = -1; t_e = -1; t_d = -1; t_p = -1; n_p = 0;
    for (int i = 1; i <= W; i++) begin
      @(negedge clk);
      if (!ana_on && t_a < 0) t_a = i;
      if (!ext_on && t_e < 0) t_e = i;
      if (!dp_on && t_d < 0) t_d = i;
      if (pd_req) begin n_p++; if (t_p < 0) t_p = i; end
    end
    check("R2 ana fall", t_a, fo + 1);
    if (eu) check("R3 ext fall", t_e, fo + 1);
    check("R4 dp fall", t_d, ho + 1);
    check("R10 pd count", n_p, em != 0 ? 1 : 0);
    if (em != 0) check("R10 pd time", t_p, fo + 1);
  endtask

  task automatic count_high(int n, output int hi, output int lo, output int first_hi);
    hi = 0; lo = 0; first_hi = -1;
    for (int i = 1; i <= n; i++) begin
      @(negedge clk);
      if (ana_on) begin hi++; if (first_hi < 0) first_hi = i; end
      else lo++;
    end
  endtask

  task automatic gap_test(int m, int exp);
    ch_en = 0;
    repeat (m) @(negedge clk);
    ch_en = 1;
    @(negedge clk);
    check("R11 overlap", int'(ovl_err), exp);
  endtask

  initial begin
    int unsigned seed;
    int hi, lo, fh;
    seed = $urandom(32'd4242);
    repeat (3) @(negedge clk);
    check("R12 reset ana", int'(ana_on), 0);
    check("R12 reset ext", int'(ext_on), 0);
    check("R12 reset dp", int'(dp_on), 0);
    check("R12 reset pulses", int'(pu_req) + int'(pd_req), 0);
    check("R12 reset ovl", int'(ovl_err), 0);
    rst_n = 1;

    run_frame(0, 0, 0, 0, 0, 0, 0, 0, 1, 1, 0);
    run_frame(5, 5, 3, 3, 5, 9, 2, 4, 0, 1, 1);
    run_frame(6, 8, 3, 3, 5, 9, 2, 4, 0, 1, 1);
    run_frame(12, 20, 7, 4, 3, 11, 2, 6, 1, 1, 3);
    run_frame(11, 11, 7, 4, 3, 11, 2, 6, 1, 0, 2);
    run_frame(10, 4, 7, 4, 1, 2, 1, 1, 1, 1, 2);
    run_frame(10, 12, 3, 6, 1, 2, 1, 1, 1, 0, 2);
    run_frame(10, 12, 6, 3, 1, 2, 1, 1, 0, 0, 2);

    for (int k = 0; k < 30; k++)
      run_frame($urandom % 31, $urandom % 41, $urandom % 26, $urandom % 26,
                $urandom % 20, $urandom % 30, $urandom % 10, $urandom % 15,
                1'($urandom), 1'($urandom), $urandom % 4);

    @(negedge clk);
    setp(10, 0, 5, 3, 0, 0, 0, 0, 1, 0, 0);
    ch_en = 1;
    count_high(4, hi, lo, fh);
    check("R5 early drop hi", hi, 0);
    ch_en = 0;
    count_high(20, hi, lo, fh);
    check("R5 cancelled rise", hi, 0);
    check("R4 dp after cancel", int'(dp_on), 0);
    ch_en = 1;
    count_high(15, hi, lo, fh);
    check("R5 R1 restart rise", fh, 11);
    ch_en = 0;
    repeat (2) @(negedge clk);
    ch_en = 1;
    @(negedge clk);
    check("R11 overlap short", int'(ovl_err), 1);
    count_high(10, hi, lo, fh);
    check("R5 cancelled fall", lo, 0);
    gap_test(3, 0);
    gap_test(2, 1);
    repeat (20) @(negedge clk);

    setp(10, 0, 5, 3, 2, 20, 4, 9, 1, 0, 1);
    #1;
    check("R8 mode1", int'(psm_eff), 1);
    gap_test(6, 1);
    repeat (20) @(negedge clk);
    gap_test(7, 0);
    repeat (20) @(negedge clk);
    gap_test(W, 0);
    ch_en = 0;
    repeat (30) @(negedge clk);

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule